// File: doc/BRIEF.md
# Configurable Logic Cell

A single programmable logic cell of the kind tiled across a field-programmable fabric. Two 4-input function generators, each a 16-entry by 1-bit table addressed by its own four inputs, can implement any Boolean function of those inputs. A third, 8-entry table combines the two table outputs with one extra direct input. Two storage elements take their data from any of the three function generators or from a direct data input. Each can be configured as an edge-triggered flip-flop or as a level-sensitive latch, with its own clock polarity, clock enable and set/reset behaviour.

All configuration lives in one 56-bit register. It is written whole through a parallel port or bit by bit through a serial shift port, while the cell is otherwise idle. Either main table may be switched into RAM mode. It then becomes a 16x1 memory that is written synchronously at the address on its own four inputs and read combinationally through the same path. The cell drives two combinational outputs and two storage-element outputs.

Top module: `logic_cell`

## Requirements
- R1: While `rst_n` is low the configuration register is all zeros and both storage outputs are 0. With zero configuration every table reads 0.
- R2: When `cfg_load` is high at a rising clock edge, the configuration becomes `cfg_par`. Bits [15:0] hold table F, [31:16] table G and [39:32] the combining table H. Bit 40 puts F and bit 41 puts G in RAM mode. Bits 42 and 43 route H instead of F or G to `comb_x` or `comb_y`. Bits [49:44] configure storage element 0 and bits [55:50] configure element 1.
- R3: When `cfg_shift` is high and `cfg_load` is low at a rising edge, the configuration shifts up by one bit and `cfg_sin` enters bit 0. The most significant bit is therefore sent first.
- R4: Table F outputs bit `f_in` of its 16 bits, and table G outputs bit `g_in` of its 16 bits. `comb_x` shows F when bit 42 is 0, and `comb_y` shows G when bit 43 is 0.
- R5: Table H outputs its bit at index {`h1_in`, G output, F output}, with the F output in the least significant place. `comb_x` or `comb_y` shows H when its routing bit is 1.
- R6: When a table's RAM bit is set and `we` is high at a rising edge with no configuration load or shift, `wdata` is written into that table at the address on its own inputs. The new value is visible combinationally afterwards.
- R7: A table whose RAM bit is clear, or any table while `we` is low, keeps its contents.
- R8: Within an element's 6-bit field, bits [1:0] choose its data: 0 = F, 1 = G, 2 = H, 3 = `din[i]`.
- R9: In flip-flop mode (field bit 2 = 0), the element loads its data on the active clock edge when `ce[i]` is high, and holds its value when `ce[i]` is low.
- R10: Field bit 3 = 1 makes the active edge of a flip-flop the falling clock edge instead of the rising one.
- R11: In latch mode (field bit 2 = 1), the element is transparent while the clock is high (bit 3 = 0) or low (bit 3 = 1), and holds its value during the opposite clock level.
- R12: When field bit 5 = 0, a high `sr` forces the element to the value in field bit 4 at the active edge, or while the latch is open, regardless of `ce`.
- R13: When field bit 5 = 1, a high `sr` forces the element to the value in field bit 4 at once, without waiting for a clock edge and regardless of `ce`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cell clock for configuration, table RAM writes and storage elements |
| rst_n | input | 1 | Active-low asynchronous reset of configuration and storage |
| cfg_load | input | 1 | Parallel configuration load strobe |
| cfg_par | input | 56 | Parallel configuration word |
| cfg_shift | input | 1 | Serial configuration shift strobe |
| cfg_sin | input | 1 | Serial configuration data bit |
| f_in | input | 4 | Address inputs of table F |
| g_in | input | 4 | Address inputs of table G |
| h1_in | input | 1 | Extra direct input of the combining table |
| din | input | 2 | Direct data input per storage element |
| ce | input | 2 | Clock enable per storage element |
| sr | input | 1 | Shared set/reset control |
| we | input | 1 | Table RAM write enable |
| wdata | input | 1 | Table RAM write data |
| comb_x | output | 1 | Combinational output, F or H |
| comb_y | output | 1 | Combinational output, G or H |
| reg_q | output | 2 | Storage element outputs |

## Verification
The assertions check several behaviours on every cycle. A parallel load or a serial shift must give exactly the expected configuration one edge later. A RAM write must land at the address presented on the previous edge, and a table with no write must stay stable. A rising-edge flip-flop must capture its data, hold it when `ce` is low, and obey a synchronous set/reset. An asynchronous set/reset must pin the output at every sampled edge. Only the bench scenarios can show the rest. These cover the falling-edge variant, which the rising-edge sampling cannot follow, and latch transparency and hold at mid-cycle times. They also cover the bit order of the serial stream and the immediate effect of an asynchronous set/reset between edges.

// File: rtl/cell_pkg.sv
`timescale 1ns/1ps
package cell_pkg;
  localparam int LUT_IN  = 4;
  localparam int LUT_SZ  = 1 << LUT_IN;
  localparam int CMB_IN  = 3;
  localparam int CMB_SZ  = 1 << CMB_IN;
  localparam int N_TBL   = 2;
  localparam int N_STORE = 2;
  localparam int ST_BITS = 6;
  localparam int CFG_W   = N_TBL*LUT_SZ + CMB_SZ + 2*N_TBL + N_STORE*ST_BITS;

  typedef enum logic [1:0] {
    SRC_F   = 2'd0,
    SRC_G   = 2'd1,
    SRC_H   = 2'd2,
    SRC_DIN = 2'd3
  } src_e;

  typedef struct packed {
    logic async_sr;
    logic sr_val;
    logic clk_inv;
    logic latch;
    src_e src;
  } store_cfg_t;

  typedef struct packed {
    store_cfg_t [N_STORE-1:0]         st;
    logic [N_TBL-1:0]                 out_h;
    logic [N_TBL-1:0]                 ram;
    logic [CMB_SZ-1:0]                h;
    logic [N_TBL-1:0][LUT_SZ-1:0]     lut;
  } cfg_t;

  function automatic logic lut_read(input logic [LUT_SZ-1:0] tbl,
                                    input logic [LUT_IN-1:0] addr);
    return tbl[addr];
  endfunction

  function automatic logic cmb_read(input logic [CMB_SZ-1:0] tbl,
                                    input logic fo, input logic go,
                                    input logic xi);
    return tbl[{xi, go, fo}];
  endfunction
endpackage

// File: rtl/cell_cfg.sv
`timescale 1ns/1ps
module cell_cfg
  import cell_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           load,
  input  logic [CFG_W-1:0]               par,
  input  logic                           shift,
  input  logic                           sin,
  input  logic                           we,
  input  logic                           wdata,
  input  logic [N_TBL-1:0][LUT_IN-1:0]   addr,
  output cfg_t                           cfg,
  output logic [N_TBL-1:0]               ram_wr
);
  logic cfg_busy;
  assign cfg_busy = load | shift;

  for (genvar t = 0; t < N_TBL; t++) begin : g_wr
    assign ram_wr[t] = we & cfg.ram[t] & ~cfg_busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (load) begin
      cfg <= cfg_t'(par);
    end else if (shift) begin
      cfg <= cfg_t'({cfg[CFG_W-2:0], sin});
    end else begin
      for (int t = 0; t < N_TBL; t++) begin
        if (ram_wr[t]) cfg.lut[t][addr[t]] <= wdata;
      end
    end
  end

  a_r2_par_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cfg == $past(par)));

  a_r3_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> (cfg[0] == $past(sin)) && (cfg[CFG_W-1:1] == $past(cfg[CFG_W-2:0])));

  a_r6_ram_f_write: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr[0] |=> (cfg.lut[0][$past(addr[0])] == $past(wdata)));

  a_r6_ram_g_write: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr[1] |=> (cfg.lut[1][$past(addr[1])] == $past(wdata)));

  a_r7_tbl_f_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_busy && !ram_wr[0]) |=> $stable(cfg.lut[0]));

  a_r7_tbl_g_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_busy && !ram_wr[1]) |=> $stable(cfg.lut[1]));
endmodule

// File: rtl/cell_fgen.sv
`timescale 1ns/1ps
module cell_fgen
  import cell_pkg::*;
(
  input  cfg_t                           cfg,
  input  logic [N_TBL-1:0][LUT_IN-1:0]   addr,
  input  logic                           xi,
  output logic [N_TBL-1:0]               lut_o,
  output logic                           h_o,
  output logic [N_TBL-1:0]               comb
);
  for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
    assign lut_o[t] = lut_read(cfg.lut[t], addr[t]);
    assign comb[t]  = cfg.out_h[t] ? h_o : lut_o[t];
  end

  assign h_o = cmb_read(cfg.h, lut_o[0], lut_o[1], xi);
endmodule

// File: rtl/cell_store.sv
`timescale 1ns/1ps
module cell_store
  import cell_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  store_cfg_t c,
  input  logic [3:0] d_opts,
  input  logic       ce,
  input  logic       sr,
  output logic       q
);
  logic d;
  logic arst;
  logic arst_val;
  logic sync_sr;
  logic open_lvl;
  logic q_p;
  logic q_n;
  logic q_l;

  assign d        = d_opts[c.src];
  assign arst     = ~rst_n | (sr & c.async_sr);
  assign arst_val = rst_n & c.sr_val;
  assign sync_sr  = sr & ~c.async_sr;
  assign open_lvl = clk ^ c.clk_inv;

  always_ff @(posedge clk or posedge arst) begin
    if (arst)         q_p <= arst_val;
    else if (sync_sr) q_p <= c.sr_val;
    else if (ce)      q_p <= d;
  end

  always_ff @(negedge clk or posedge arst) begin
    if (arst)         q_n <= arst_val;
    else if (sync_sr) q_n <= c.sr_val;
    else if (ce)      q_n <= d;
  end

  always_latch begin
    if (arst) begin
      q_l <= arst_val;
    end else if (open_lvl) begin
      if (sync_sr)  q_l <= c.sr_val;
      else if (ce)  q_l <= d;
    end
  end

  assign q = c.latch ? q_l : (c.clk_inv ? q_n : q_p);

  a_r13_async_force: assert property (@(posedge clk) disable iff (!rst_n)
    (sr && c.async_sr) |-> (q == c.sr_val));

  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!c.latch && !c.clk_inv && ce && !sr) |=> ((!sr && $stable(c)) -> (q == $past(d))));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!c.latch && !c.clk_inv && !ce && !sr) |=> ((!sr && $stable(c)) -> $stable(q)));

  a_r12_sync_force: assert property (@(posedge clk) disable iff (!rst_n)
    (!c.latch && !c.clk_inv && sr && !c.async_sr) |=> ($stable(c) -> (q == $past(c.sr_val))));
endmodule

// File: rtl/logic_cell.sv
`timescale 1ns/1ps
module logic_cell
  import cell_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_load,
  input  logic [CFG_W-1:0]      cfg_par,
  input  logic                  cfg_shift,
  input  logic                  cfg_sin,
  input  logic [LUT_IN-1:0]     f_in,
  input  logic [LUT_IN-1:0]     g_in,
  input  logic                  h1_in,
  input  logic [N_STORE-1:0]    din,
  input  logic [N_STORE-1:0]    ce,
  input  logic                  sr,
  input  logic                  we,
  input  logic                  wdata,
  output logic                  comb_x,
  output logic                  comb_y,
  output logic [N_STORE-1:0]    reg_q
);
  cfg_t                          cfg;
  logic [N_TBL-1:0][LUT_IN-1:0]  addr;
  logic [N_TBL-1:0]              ram_wr;
  logic [N_TBL-1:0]              lut_o;
  logic [N_TBL-1:0]              comb;
  logic                          h_o;

  assign addr = {g_in, f_in};

  cell_cfg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (cfg_load),
    .par    (cfg_par),
    .shift  (cfg_shift),
    .sin    (cfg_sin),
    .we     (we),
    .wdata  (wdata),
    .addr   (addr),
    .cfg    (cfg),
    .ram_wr (ram_wr)
  );

  cell_fgen u_fgen (
    .cfg   (cfg),
    .addr  (addr),
    .xi    (h1_in),
    .lut_o (lut_o),
    .h_o   (h_o),
    .comb  (comb)
  );

  assign comb_x = comb[0];
  assign comb_y = comb[1];

  for (genvar s = 0; s < N_STORE; s++) begin : g_st
    cell_store u_st (
      .clk    (clk),
      .rst_n  (rst_n),
      .c      (cfg.st[s]),
      .d_opts ({din[s], h_o, lut_o[1], lut_o[0]}),
      .ce     (ce[s]),
      .sr     (sr),
      .q      (reg_q[s])
    );
  end

  a_r1_reset_outputs: assert property (@(posedge clk)
    !rst_n |-> (reg_q == '0) && !comb_x && !comb_y);
endmodule

// File: tb/test_logic_cell.sv
`timescale 1ns/1ps
module test_logic_cell;
  localparam int W = 56;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_load, cfg_shift, cfg_sin;
  logic [W-1:0]  cfg_par;
  logic [3:0]    f_in, g_in;
  logic          h1_in, sr, we, wdata;
  logic [1:0]    din, ce;
  logic          comb_x, comb_y;
  logic [1:0]    reg_q;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  logic_cell i_logic_cell (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_par(cfg_par),
    .cfg_shift(cfg_shift), .cfg_sin(cfg_sin), .f_in(f_in), .g_in(g_in),
    .h1_in(h1_in), .din(din), .ce(ce), .sr(sr), .we(we), .wdata(wdata),
    .comb_x(comb_x), .comb_y(comb_y), .reg_q(reg_q)
  );

  typedef struct packed {
    logic [3:0] f;
    logic [3:0] g;
    logic       x1;
    logic       ex;
    logic       ey;
  } vec_t;

  // Config A: F = 4-input AND, G = parity, H = majority, comb_y routed to H
  localparam vec_t VECS [6] = '{
    '{4'hF, 4'h0, 1'b0, 1'b1, 1'b0},
    '{4'hE, 4'h1, 1'b1, 1'b0, 1'b1},
    '{4'hF, 4'h7, 1'b0, 1'b1, 1'b1},
    '{4'h0, 4'h3, 1'b1, 1'b0, 1'b0},
    '{4'h7, 4'h8, 1'b0, 1'b0, 1'b0},
    '{4'hF, 4'hF, 1'b1, 1'b1, 1'b1}
  };

  // element field: {async, value, invert, latch, source[1:0]}
  function automatic logic [W-1:0] mk(input logic [15:0] f, input logic [15:0] g,
                                      input logic [7:0] h, input logic [1:0] ram,
                                      input logic [1:0] oh, input logic [5:0] s0,
                                      input logic [5:0] s1);
    return {s1, s0, oh, ram, h, g, f};
  endfunction

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic load_par(input logic [W-1:0] c);
    cfg_par = c; cfg_load = 1'b1;
    step();
    cfg_load = 1'b0;
  endtask

  task automatic load_ser(input logic [W-1:0] c);
    for (int i = W-1; i >= 0; i--) begin
      cfg_sin = c[i]; cfg_shift = 1'b1;
      step();
    end
    cfg_shift = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #50000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_load = 0; cfg_shift = 0; cfg_sin = 0; cfg_par = '0;
    f_in = 4'hF; g_in = 0; h1_in = 0; din = 0; ce = 0; sr = 0; we = 0; wdata = 0;
    repeat (3) step();
    chk("R1 reset q0", reg_q[0], 1'b0);
    chk("R1 reset q1", reg_q[1], 1'b0);
    chk("R1 reset table", comb_x, 1'b0);
    rst_n = 1'b1;
    step();

    // R2, R4, R5: vector walk over config A
    load_par(mk(16'h8000, 16'h6996, 8'hE8, 2'b00, 2'b10, 6'b000011, 6'b000010));
    foreach (VECS[k]) begin
      f_in = VECS[k].f; g_in = VECS[k].g; h1_in = VECS[k].x1;
      #1;
      chk("R4 comb_x from F", comb_x, VECS[k].ex);
      chk("R5 comb_y from H", comb_y, VECS[k].ey);
      step();
    end

    // R3: serial load, MSB first; routing bit 43 and H = all ones
    load_ser(mk(16'h00F0, 16'h0000, 8'hFF, 2'b00, 2'b10, 6'b0, 6'b0));
    f_in = 4'h4; #1;
    chk("R3 serial F bit4", comb_x, 1'b1);
    chk("R3 serial high bits", comb_y, 1'b1);
    f_in = 4'h8; #1;
    chk("R3 serial F bit8", comb_x, 1'b0);
    step();

    // R6, R7: F in RAM mode, G not
    load_par(mk(16'h0, 16'h0, 8'h0, 2'b01, 2'b00, 6'b0, 6'b0));
    f_in = 4'h5; wdata = 1'b1; we = 1'b1;
    step();
    we = 1'b0; #1;
    chk("R6 ram write read back", comb_x, 1'b1);
    f_in = 4'h4; #1;
    chk("R6 neighbour untouched", comb_x, 1'b0);
    f_in = 4'h6; wdata = 1'b1;
    step(); #1;
    chk("R7 we low no write", comb_x, 1'b0);
    g_in = 4'h3; we = 1'b1;
    step();
    we = 1'b0; #1;
    chk("R7 non-ram table kept", comb_y, 1'b0);
    wdata = 1'b0;

    // R8, R9, R12: element 0 rising FF from din, element 1 rising FF from F
    load_par(mk(16'h0002, 16'h0, 8'h0, 2'b00, 2'b00, 6'b000011, 6'b000000));
    din[0] = 1'b1; ce[0] = 1'b1; #1;
    chk("R9 no change before edge", reg_q[0], 1'b0);
    step();
    chk("R9 capture on rise", reg_q[0], 1'b1);
    ce[0] = 1'b0; din[0] = 1'b0;
    step();
    chk("R9 hold with ce low", reg_q[0], 1'b1);
    ce[1] = 1'b1; f_in = 4'h1;
    step();
    chk("R8 source F high", reg_q[1], 1'b1);
    f_in = 4'h0;
    step();
    chk("R8 source F low", reg_q[1], 1'b0);
    ce[1] = 1'b0;
    sr = 1'b1; #1;
    chk("R12 sync waits for edge", reg_q[0], 1'b1);
    step();
    chk("R12 sync reset despite ce low", reg_q[0], 1'b0);
    sr = 1'b0;

    // R13, R10: element 0 async set from din, element 1 falling-edge FF
    load_par(mk(16'h0, 16'h0, 8'h0, 2'b00, 2'b00, 6'b110011, 6'b001011));
    ce = 2'b01; din = 2'b00; sr = 1'b1; #1;
    chk("R13 async set immediate", reg_q[0], 1'b1);
    step();
    chk("R13 async beats ce", reg_q[0], 1'b1);
    sr = 1'b0;
    step();
    chk("R10 falling FF sync reset", reg_q[1], 1'b0);
    ce = 2'b10; din[1] = 1'b1; #1;
    chk("R10 no capture on rise", reg_q[1], 1'b0);
    @(negedge clk); #1;
    chk("R10 capture on fall", reg_q[1], 1'b1);
    step();

    // R11: element 0 latch open high, element 1 latch open low; comb_y = H all ones
    load_par(mk(16'h0, 16'h0, 8'hFF, 2'b00, 2'b10, 6'b000111, 6'b001111));
    ce = 2'b11; din[0] = 1'b1; #1;
    chk("R11 latch open while high", reg_q[0], 1'b1);
    @(negedge clk); #1;
    din[0] = 1'b0; din[1] = 1'b1; #1;
    chk("R11 latch holds while low", reg_q[0], 1'b1);
    chk("R11 inverted latch open low", reg_q[1], 1'b1);
    step();
    din[1] = 1'b0; #1;
    chk("R11 inverted latch holds high", reg_q[1], 1'b1);

    // R1: reset mid-run
    rst_n = 1'b0; #1;
    chk("R1 reset clears q0", reg_q[0], 1'b0);
    chk("R1 reset clears q1", reg_q[1], 1'b0);
    chk("R1 reset clears config", comb_y, 1'b0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule